// File: doc/BRIEF.md
# Add/Subtract Accumulator with Hexadecimal Display

This block keeps an 8-bit running total that changes on every rising clock edge. A one-bit direction input chooses whether the 4-bit input value is added to the total or taken away from it. The sum wraps modulo 256, and no carry or borrow is kept.

A three-state machine records what happened on the most recent edge: a reset (init), an addition or a subtraction. The state is brought out on a port so that it can be observed. The total is split into two nibbles, and each nibble drives a seven-segment digit that shows one hexadecimal character. This lets the running value be watched as it changes. The raw total is also brought out for checking.

Top module: `acc_hex_display`

## Requirements
- R1: One rising edge with `rst` high sets `total` to 0x00 and `mode` to 2'b00 (init). Both values hold until the first operation edge that follows.
- R2: On an edge with `rst` low and `dir_sub` = 0, `total` becomes the old total plus `val`, with `val` zero-extended to 8 bits.
- R3: On an edge with `rst` low and `dir_sub` = 1, `total` becomes the old total minus the zero-extended `val`.
- R4: The arithmetic wraps modulo 256. For example, 0x00 - 1 gives 0xFF and 0xFF + 1 gives 0x00.
- R5: When `rst` is high it takes priority over `dir_sub` and `val`. The edge clears the total whatever the other inputs are.
- R6: `mode` reads 2'b01 after an add edge and 2'b10 after a subtract edge. It never takes the value 2'b11.
- R7: `seg_lo` shows `total[3:0]` active-low, with bit order {g,f,e,d,c,b,a}. The active-high glyph patterns, digits 0 to F, are: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. `seg_lo` is the bitwise inverse of the pattern for its digit.
- R8: `seg_hi` shows `total[7:4]` using the same encoding as R7.
- R9: The segment outputs are purely combinational from the register. They match the new total in the same cycle that the total changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the total updates on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| dir_sub | input | 1 | Direction select: 0 adds, 1 subtracts |
| val | input | 4 | Unsigned amount to accumulate |
| total | output | 8 | Current accumulator value |
| mode | output | 2 | Last action: 00 init, 01 add, 10 sub |
| seg_hi | output | 7 | Active-low segments for the upper nibble |
| seg_lo | output | 7 | Active-low segments for the lower nibble |

## Verification
A short directed run alternates additions and subtractions using known values. This shows that the direction select is obeyed and that `val` is zero-extended and not sign-extended. It also crosses 0x00 in both directions, which separates modular wrap from saturation. A reset is applied while subtract is selected with a nonzero value, to show that the clear takes priority. Long runs of adds with 0xF and a pseudo-random mix then drive both nibbles through all sixteen glyphs, so that every segment pattern on each digit is compared against the table.

// File: rtl/acc_hex_display.sv
module acc_hex_display #(
  parameter int VAL_W = 4,
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_sub,
  input  logic [VAL_W-1:0] val,
  output logic [ACC_W-1:0] total,
  output logic [1:0]       mode,
  output logic [6:0]       seg_hi,
  output logic [6:0]       seg_lo
);

  localparam int PAD_W = ACC_W - VAL_W;

  typedef enum logic [1:0] {ST_INIT = 2'b00, ST_ADD = 2'b01, ST_SUB = 2'b10} mode_t;

  mode_t             state;
  logic [ACC_W-1:0]  operand;

  assign operand = {{PAD_W{1'b0}}, val};

  always_ff @(posedge clk) begin
    if (rst) begin
      total <= '0;
      state <= ST_INIT;
    end else if (dir_sub) begin
      total <= total - operand;
      state <= ST_SUB;
    end else begin
      total <= total + operand;
      state <= ST_ADD;
    end
  end

  assign mode = state;

  function automatic logic [6:0] glyph(input logic [3:0] nib);
    logic [6:0] on;
    case (nib)
      4'h0: on = 7'b0111111;
      4'h1: on = 7'b0000110;
      4'h2: on = 7'b1011011;
      4'h3: on = 7'b1001111;
      4'h4: on = 7'b1100110;
      4'h5: on = 7'b1101101;
      4'h6: on = 7'b1111101;
      4'h7: on = 7'b0000111;
      4'h8: on = 7'b1111111;
      4'h9: on = 7'b1101111;
      4'hA: on = 7'b1110111;
      4'hB: on = 7'b1111100;
      4'hC: on = 7'b0111001;
      4'hD: on = 7'b1011110;
      4'hE: on = 7'b1111001;
      default: on = 7'b1110001;
    endcase
    return ~on;
  endfunction

  assign seg_lo = glyph(total[3:0]);
  assign seg_hi = glyph(total[ACC_W-1 -: 4]);

  // R1: the cycle after a reset edge shows a cleared total in init
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (total == '0 && mode == 2'b00));

  // R2 / R4
  p_add_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!dir_sub) |=> (total == ACC_W'($past(total) + {{PAD_W{1'b0}}, $past(val)})));

  // R3 / R4
  p_sub_step_r3: assert property (@(posedge clk) disable iff (rst)
    dir_sub |=> (total == ACC_W'($past(total) - {{PAD_W{1'b0}}, $past(val)})));

  p_mode_add_r6: assert property (@(posedge clk) disable iff (rst)
    (!dir_sub) |=> (mode == 2'b01));

  p_mode_sub_r6: assert property (@(posedge clk) disable iff (rst)
    dir_sub |=> (mode == 2'b10));

  p_mode_legal_r6: assert property (@(posedge clk) disable iff (rst)
    mode != 2'b11);

endmodule

// File: tb/acc_hex_display_tb_top.sv
module acc_hex_display_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir_sub = 1'b0;
  logic [3:0] val = 4'h0;
  logic [7:0] total;
  logic [1:0] mode;
  logic [6:0] seg_hi, seg_lo;

  always #2 clk = ~clk;

  acc_hex_display dut_i (
    .clk(clk), .rst(rst), .dir_sub(dir_sub), .val(val),
    .total(total), .mode(mode), .seg_hi(seg_hi), .seg_lo(seg_lo)
  );

  typedef struct {
    logic [7:0] tot;
    logic [1:0] md;
    string      tag;
  } item_t;

  item_t      sb[$];
  int         checks = 0;
  int         errors = 0;
  logic [7:0] model = 8'h00;
  logic       done = 1'b0;

  function automatic logic [6:0] expect_seg(input logic [3:0] d);
    logic [7:0] lit [16] = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66, 8'h6D, 8'h7D, 8'h07,
                             8'h7F, 8'h6F, 8'h77, 8'h7C, 8'h39, 8'h5E, 8'h79, 8'h71};
    logic [7:0] p;
    p = lit[d];
    return ~p[6:0];
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic s, input logic [3:0] v, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; dir_sub = s; val = v;
    if (r) begin
      model = 8'h00; it.md = 2'b00;
    end else if (s) begin
      model = model - {4'h0, v}; it.md = 2'b10;
    end else begin
      model = model + {4'h0, v}; it.md = 2'b01;
    end
    it.tot = model; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: one result per edge, sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " total"}, total, it.tot);
        check({it.tag, " mode R6"}, {6'b0, mode}, {6'b0, it.md});
        check("R7/R9 seg_lo", {1'b0, seg_lo}, {1'b0, expect_seg(it.tot[3:0])});
        check("R8/R9 seg_hi", {1'b0, seg_hi}, {1'b0, expect_seg(it.tot[7:4])});
      end
    end
  end

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'h5A;
    step(1, 0, 4'h0, "R1 reset");
    step(1, 0, 4'h0, "R1 reset hold");
    step(0, 0, 4'h5, "R2 add");
    step(0, 0, 4'hF, "R2 add zero-extend");
    step(0, 1, 4'h3, "R3 sub");
    step(0, 1, 4'hF, "R3 sub zero-extend");
    step(0, 1, 4'h3, "R4 borrow wrap");
    step(0, 0, 4'h1, "R4 carry wrap");
    for (int i = 0; i < 20; i++) step(0, 0, 4'hF, "R2 add sweep");
    step(1, 1, 4'hF, "R5 reset over sub");
    step(0, 0, 4'h9, "R2 add after reset");
    step(1, 0, 4'h7, "R5 reset over add");
    for (int i = 0; i < 20; i++) step(0, 1, 4'hB, "R3 sub sweep");
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(0, lfsr[0], lfsr[7:4], "R4 mixed");
    end
    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule